// File: doc/BRIEF.md
# I2C Register Target with Command Decode

This block is an I2C bus target that exposes a 16-byte read-only register window to a host processor and accepts short command writes from it. Another block on the chip, such as a key matrix scanner, fills the window through a simple synchronous write port. The host reads the window by addressing the target for a read: data always starts from offset 0 after a STOP and steps forward one byte per transfer. Offsets past the end of the window return 0xFF.

Writes from the host are not register writes. The first data byte of a write transaction is a command. One value pulls an open-drain interrupt line low, another releases it, and a third raises a sticky boot-request flag. The block samples SCL and SDA that are already synchronised to its clock, detects START, STOP and clock edges itself, and drives SDA only through a pull-low enable. It does not stretch the clock, and it supports neither 10-bit addressing nor general call.

Top module: `i2cs_keyreg_target`

## Requirements
- R1: After reset, `sda_oe`, `irq_oe` and `boot_req` are all 0.
- R2: The 7-bit target address is 0x15. A matching address byte is acknowledged by pulling SDA low in the ninth clock. Any other address is not acknowledged, and the block then ignores all bytes until the next START.
- R3: A read returns the window byte at the read pointer, most significant bit first, and then advances the pointer. Offset 0 resets to 0xAA, offset 1 to 0x55, and all other offsets to 0x00.
- R4: A read at an offset of 16 or more returns 0xFF, and the pointer never advances past 16.
- R5: A write on the load port sets window byte `reg_wr_idx` to `reg_wr_data` one cycle later, and later bus reads return the new value.
- R6: Every data byte of a write transaction is acknowledged, including bytes past the 16th, which are discarded. If the first data byte is 0xA0, `irq_oe` becomes 1.
- R7: A first data byte of 0xA1 clears `irq_oe`. A first data byte of 0xA2 sets `boot_req`, which stays 1 until reset. Later bytes in the same transaction, and first bytes of any other value, change neither output.
- R8: A STOP returns the read pointer and the command byte count to zero. The next read starts at offset 0, and the first byte of the next write is decoded as a command again.
- R9: When the host answers a read byte with NACK, the block releases SDA and does not drive it again until a START.
- R10: The block begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq_oe | output | 1 | 1 pulls the interrupt line low |
| boot_req | output | 1 | Sticky boot request |
| reg_wr_en | input | 1 | Load strobe for the register window |
| reg_wr_idx | input | 4 | Window offset to load |
| reg_wr_data | input | 8 | Byte to load |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except when it forms a START or STOP. Every level is held for several block clocks, so each edge is seen on its own. The load port is assumed never to write an offset at or above the window size. The bench drives both bus lines from tasks that hold every phase for 20 clocks, and it moves SDA only in the low half of SCL. The bus line seen by the block is the AND of the host drive and the target release, as on a wired-AND bus.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] CMD_IRQ_ON  = 8'hA0;
    localparam logic [7:0] CMD_IRQ_OFF = 8'hA1;
    localparam logic [7:0] CMD_BOOT    = 8'hA2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WRITE,
        PH_READ
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_IRQ_SET,
        OP_IRQ_CLR,
        OP_BOOT
    } cmd_op_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic cmd_op_e decode_cmd(input logic [7:0] b);
        case (b)
            CMD_IRQ_ON:  return OP_IRQ_SET;
            CMD_IRQ_OFF: return OP_IRQ_CLR;
            CMD_BOOT:    return OP_BOOT;
            default:     return OP_NONE;
        endcase
    endfunction

    function automatic logic [7:0] reg_init(input int unsigned idx);
        case (idx)
            0:       return 8'hAA;
            1:       return 8'h55;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2cs_bus_sense.sv
module i2cs_bus_sense
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q, sda_q, scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    always_comb begin
        ev.scl   = scl_q;
        ev.sda   = sda_q;
        ev.rise  = scl_q & ~scl_p;
        ev.fall  = ~scl_q & scl_p;
        ev.start = scl_q & scl_p & sda_p & ~sda_q;
        ev.stop  = scl_q & scl_p & ~sda_p & sda_q;
    end

endmodule

// File: rtl/i2cs_regwin.sv
module i2cs_regwin
    import i2cs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_ptr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                regs[i] <= reg_init(i);
            end else if (wr_en && wr_addr == AW'(i)) begin
                regs[i] <= wr_data;
            end
        end
    end

    assign rd_data = (rd_ptr < PW'(DEPTH)) ? regs[rd_ptr[AW-1:0]] : {BYTE_W{1'b1}};

    // R5: a load lands in the addressed byte on the next cycle
    assert_load_lands_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/i2cs_cmd_unit.sv
module i2cs_cmd_unit
    import i2cs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              irq_oe,
    output logic              boot_req
);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            irq_oe   <= 1'b0;
            boot_req <= 1'b0;
        end else if (clear) begin
            count <= '0;
        end else if (byte_vld) begin
            if (count < CW'(DEPTH)) count <= count + CW'(1);
            if (count == '0) begin
                case (decode_cmd(byte_in))
                    OP_IRQ_SET: irq_oe   <= 1'b1;
                    OP_IRQ_CLR: irq_oe   <= 1'b0;
                    OP_BOOT:    boot_req <= 1'b1;
                    default:    ;
                endcase
            end
        end
    end

    // R7: the boot request is sticky
    assert_boot_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        boot_req |=> boot_req);

    // R7: the interrupt only moves on the first byte of a transaction
    assert_irq_first_byte_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq_oe) |-> $past(byte_vld && count == '0));

    // R6: bytes past the buffer size are dropped, the count saturates
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/i2cs_keyreg_target.sv
module i2cs_keyreg_target
    import i2cs_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h15,
    parameter int         REG_DEPTH   = 16,
    parameter int         CMD_DEPTH   = 16,
    localparam int        AW          = $clog2(REG_DEPTH),
    localparam int        PW          = $clog2(REG_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              irq_oe,
    output logic              boot_req,
    input  logic              reg_wr_en,
    input  logic [AW-1:0]     reg_wr_idx,
    input  logic [BYTE_W-1:0] reg_wr_data
);

    bus_ev_t           ev;
    phase_e            phase;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [PW-1:0]     ptr;
    logic              host_ack;
    logic [BYTE_W-1:0] rd_byte;
    logic              cmd_vld;
    logic [BYTE_W-1:0] cmd_byte;
    logic              addr_hit;
    logic              ptr_in_win;
    logic              load_next;

    i2cs_bus_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cs_regwin #(.DEPTH(REG_DEPTH)) u_win (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_idx),
        .wr_data (reg_wr_data),
        .rd_ptr  (ptr),
        .rd_data (rd_byte)
    );

    i2cs_cmd_unit #(.DEPTH(CMD_DEPTH)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .clear    (ev.stop),
        .byte_vld (cmd_vld),
        .byte_in  (cmd_byte),
        .irq_oe   (irq_oe),
        .boot_req (boot_req)
    );

    assign addr_hit   = (rx_sh[7:1] == TARGET_ADDR);
    assign ptr_in_win = (ptr < PW'(REG_DEPTH));
    assign load_next  = (phase == PH_ADDR && rx_sh[0]) || (phase == PH_READ && host_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            host_ack <= 1'b0;
            cmd_vld  <= 1'b0;
            cmd_byte <= '0;
        end else begin
            cmd_vld <= 1'b0;
            if (ev.stop) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                ptr     <= '0;
            end else if (ev.start) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.rise) begin
                    if (bit_cnt < 4'd8) begin
                        rx_sh   <= {rx_sh[6:0], ev.sda};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (bit_cnt == 4'd9) begin
                        host_ack <= ~ev.sda;
                    end
                end else if (ev.fall) begin
                    if (bit_cnt == 4'd8) begin
                        // acknowledge slot begins
                        bit_cnt <= 4'd9;
                        case (phase)
                            PH_ADDR: begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                end else begin
                                    phase   <= PH_IDLE;
                                    bit_cnt <= '0;
                                end
                            end
                            PH_WRITE: begin
                                sda_oe   <= 1'b1;
                                cmd_vld  <= 1'b1;
                                cmd_byte <= rx_sh;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (bit_cnt == 4'd9) begin
                        // acknowledge slot ends
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                        if (load_next) begin
                            phase  <= PH_READ;
                            tx_sh  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            if (ptr_in_win) ptr <= ptr + PW'(1);
                        end else if (phase == PH_ADDR) begin
                            phase <= PH_WRITE;
                        end else if (phase == PH_READ) begin
                            phase <= PH_IDLE;
                        end
                    end else if (phase == PH_READ && bit_cnt != '0) begin
                        sda_oe <= ~tx_sh[6];
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R10: pulling SDA low only starts while SCL is low
    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R8: STOP leaves SDA released and the pointer at zero
    assert_stop_rewind_R8: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_oe && ptr == '0));

    // R4: the pointer never runs past the window end
    assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ptr <= PW'(REG_DEPTH));

    // R2/R9: no drive while the bus is being ignored
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IDLE |-> !sda_oe);

endmodule

// File: tb/i2cs_keyreg_target_tb_top.sv
module i2cs_keyreg_target_tb_top;

    localparam int H = 20;
    localparam logic [6:0] ADDR = 7'h15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_line;
    logic       sda_oe, irq_oe, boot_req;
    logic       reg_wr_en = 1'b0;
    logic [3:0] reg_wr_idx = '0;
    logic [7:0] reg_wr_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int oe_bad = 0;
    int oe_rises = 0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    i2cs_keyreg_target dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_drv),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .irq_oe      (irq_oe),
        .boot_req    (boot_req),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_idx  (reg_wr_idx),
        .reg_wr_data (reg_wr_data)
    );

    // port monitor for R10 and R9
    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_prev) begin
            oe_rises++;
            if (scl_drv) oe_bad++;
        end
        oe_prev <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(H);
        scl_drv = 1'b1; tick(H);
        sda_drv = 1'b0; tick(H);
        scl_drv = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(H);
        scl_drv = 1'b1; tick(H);
        sda_drv = 1'b1; tick(H);
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b; tick(H);
        scl_drv = 1'b1; tick(H);
        scl_drv = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_drv = 1'b1; tick(H);
        scl_drv = 1'b1; tick(H / 2);
        b = sda_line; tick(H / 2);
        scl_drv = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
        sda_drv = 1'b1;
    endtask

    task automatic load_reg(input logic [3:0] idx, input logic [7:0] val);
        reg_wr_idx = idx; reg_wr_data = val; reg_wr_en = 1'b1;
        tick(1);
        reg_wr_en = 1'b0;
        tick(1);
    endtask

    task automatic write_cmd(input logic [7:0] c0, input logic [7:0] c1, input int nbytes, input string tag);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        chk(a, {tag, " address ack"}, a, 1);
        for (int i = 0; i < nbytes; i++) begin
            send_byte((i == 0) ? c0 : c1, a);
            chk(a, {tag, " data ack"}, a, 1);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        chk(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
        chk(irq_oe == 0, "R1 irq_oe", irq_oe, 0);
        chk(boot_req == 0, "R1 boot_req", boot_req, 0);
    endtask

    task automatic t_default_read();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        chk(a, "R2 read address ack", a, 1);
        recv_byte(d, 1'b1); chk(d == 8'hAA, "R3 offset0", d, 8'hAA);
        recv_byte(d, 1'b1); chk(d == 8'h55, "R3 offset1", d, 8'h55);
        recv_byte(d, 1'b0); chk(d == 8'h00, "R3 offset2", d, 8'h00);
        bus_stop();
    endtask

    task automatic t_load_and_read();
        logic a;
        logic [7:0] d, e;
        load_reg(4'd2, 8'h3C);
        load_reg(4'd15, 8'hC3);
        load_reg(4'd7, 8'h81);
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        chk(a, "R2 read address ack", a, 1);
        for (int i = 0; i < 18; i++) begin
            recv_byte(d, i != 17);
            case (i)
                0: e = 8'hAA;
                1: e = 8'h55;
                2: e = 8'h3C;
                7: e = 8'h81;
                15: e = 8'hC3;
                16, 17: e = 8'hFF;
                default: e = 8'h00;
            endcase
            if (i >= 16) chk(d == e, "R4 beyond window", d, e);
            else chk(d == e, "R5 loaded window byte", d, e);
        end
        bus_stop();
    endtask

    task automatic t_pointer_restart();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        recv_byte(d, 1'b0);
        chk(d == 8'hAA, "R8 pointer rewound after STOP", d, 8'hAA);
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte({7'h16, 1'b0}, a);
        chk(!a, "R2 foreign address nack", a, 0);
        send_byte(8'hA0, a);
        chk(!a, "R2 ignored byte nack", a, 0);
        bus_stop();
        chk(irq_oe == 0, "R2 ignored command", irq_oe, 0);
    endtask

    task automatic t_cmd_irq();
        write_cmd(8'hA0, 8'h00, 1, "R6");
        chk(irq_oe == 1, "R6 irq set by A0", irq_oe, 1);
        write_cmd(8'h55, 8'h00, 1, "R7");
        chk(irq_oe == 1, "R7 unknown command no effect", irq_oe, 1);
        write_cmd(8'hA1, 8'hA0, 2, "R7");
        chk(irq_oe == 0, "R7 only first byte decoded", irq_oe, 0);
        write_cmd(8'hA0, 8'hA1, 20, "R6");
        chk(irq_oe == 1, "R6 long write first byte wins", irq_oe, 1);
        write_cmd(8'hA1, 8'h00, 1, "R8");
        chk(irq_oe == 0, "R8 count cleared by STOP", irq_oe, 0);
    endtask

    task automatic t_boot();
        write_cmd(8'hA2, 8'h00, 1, "R7");
        chk(boot_req == 1, "R7 boot set", boot_req, 1);
        write_cmd(8'hA1, 8'h00, 1, "R7");
        chk(boot_req == 1, "R7 boot sticky", boot_req, 1);
        chk(irq_oe == 0, "R7 irq released", irq_oe, 0);
    endtask

    task automatic t_nack_release();
        logic a, b;
        logic [7:0] d;
        int r0;
        load_reg(4'd0, 8'h00);
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        recv_byte(d, 1'b0);
        chk(d == 8'h00, "R9 read before nack", d, 8'h00);
        r0 = oe_rises;
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            chk(b == 1'b1, "R9 bus released after nack", b, 1);
        end
        chk(oe_rises == r0, "R9 no drive after nack", oe_rises, r0);
        bus_stop();
    endtask

    initial begin
        tick(200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(5);
        t_reset();
        rst = 1'b0;
        tick(5);
        t_reset();
        t_default_read();
        t_load_and_read();
        t_pointer_restart();
        t_wrong_addr();
        t_cmd_irq();
        t_boot();
        t_nack_release();
        chk(oe_bad == 0, "R10 drive began with SCL high", oe_bad, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule